// File: doc/BRIEF.md
# MII Receive Deframer with Frame Check

This block sits directly behind a 10/100 Ethernet PHY on the 4-bit media independent receive path, in the receive clock domain (25 MHz at 100 Mb/s). It samples one nibble per clock while the PHY's data-valid line is high. Nibbles are joined into bytes with the first nibble of each pair taken as the low half.

The block hunts for the run of preamble nibbles and the start-of-frame delimiter. It drops both and hands every following byte (destination address through the trailing frame check sequence) to the next stage as a byte stream. The stream carries a one-cycle strobe per byte and marks the first and last byte of each frame. It also carries three status bits with the last byte:
- a CRC-32 residue match,
- a frame that stopped on half a byte,
- a frame shorter than the minimum Ethernet size.

Bursts that never reach a delimiter, or that carry a foreign nibble before it, produce no output.

Top module: `mii_rx_deframer`

## Requirements
- R1: Each byte is assembled from two consecutive accepted nibbles, the first forming bits 3:0 and the second bits 7:4 (nibbles 0x0 then 0x1 give byte 0x10).
- R2: While waiting for a frame, a data-valid burst that opens with one or more nibbles of 0x5 followed by a nibble of 0xD starts a frame. None of those nibbles are delivered, and the first output byte is built from the two nibbles right after the 0xD.
- R3: Nibbles are accepted only in cycles where `mii_dv` is high. If `mii_dv` falls before the 0xD delimiter nibble, the burst is discarded and nothing is delivered.
- R4: A nibble other than 0x5 or 0xD before the delimiter, including a first nibble other than 0x5, discards the rest of the burst until `mii_dv` goes low, even if a 0x5/0xD sequence follows.
- R5: `out_sof` is high with the first byte of a frame and `out_eof` with the last, both only while `out_valid` is high. A one-byte frame has both set on the same byte.
- R6: Every complete byte after the delimiter is delivered exactly once and in order, including the four check-sequence bytes at the end.
- R7: `out_crc_ok` is high with the last byte exactly when a reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF) run over all delivered bytes of the frame leaves the good-frame residue. That residue is 0xC704DD7B in normal bit order, or 0xDEBB20E3 as held in the right-shifting register.
- R8: `out_odd` is high with the last byte when `mii_dv` falls after an odd number of nibbles past the delimiter. The stray nibble is not delivered and does not enter the CRC.
- R9: `out_runt` is high with the last byte when the frame held fewer than MIN_FRAME_BYTES (default 64) bytes including the check sequence.
- R10: A byte is presented, for one cycle of `out_valid`, in the cycle after the following byte completes. The last byte is presented in the cycle after `mii_dv` is first sampled low.
- R11: While reset is asserted and after its release with no input activity, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mii_dv | input | 1 | Receive data valid from the PHY |
| mii_rxd | input | 4 | Receive nibble from the PHY |
| out_valid | output | 1 | Byte strobe, one cycle per delivered byte |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_crc_ok | output | 1 | Residue matched (with out_eof) |
| out_odd | output | 1 | Frame ended on half a byte (with out_eof) |
| out_runt | output | 1 | Frame below minimum size (with out_eof) |

## Verification
The hardest condition to reach from the ports is the end-of-frame status itself. The last byte can only be marked once `mii_dv` has fallen, so the good, corrupted, odd-length and runt cases each need a complete frame, with a correct check sequence computed in the bench. The driver builds every frame from a payload pattern and appends the inverted CRC low byte first. It then optionally flips one payload bit after the check sequence is fixed, or adds one trailing nibble. Discarded bursts are produced by dropping `mii_dv` inside the preamble and by inserting a foreign nibble ahead of a valid-looking delimiter. The bench then confirms that no byte reached the output.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam int unsigned CRC_W  = 32;

  localparam logic [NIB_W-1:0] PREAMBLE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] DELIM_NIB    = 4'hD;

  // Reflected form of 0x04C11DB7, register shifts toward bit 0.
  localparam logic [CRC_W-1:0] CRC_POLY_RFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFFFFFF;
  // Good-frame remainder seen in the shifting register (0xC704DD7B bit-reversed).
  localparam logic [CRC_W-1:0] CRC_GOOD_REM = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_PREAM = 2'd1,
    RX_DATA  = 2'd2,
    RX_SKIP  = 2'd3
  } rx_state_e;

  function automatic logic [CRC_W-1:0] crc_step_byte(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] din
  );
    logic [CRC_W-1:0] acc;
    acc = cur ^ {{(CRC_W-BYTE_W){1'b0}}, din};
    for (int k = 0; k < BYTE_W; k++) begin
      if (acc[0]) acc = (acc >> 1) ^ CRC_POLY_RFL;
      else        acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/mii_rx_sfd_fsm.sv
module mii_rx_sfd_fsm
  import mii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             frame_start,
  output logic             nib_vld,
  output logic             frame_end
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    frame_start = 1'b0;
    nib_vld     = 1'b0;
    frame_end   = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (dv) begin
          if (rxd == PREAMBLE_NIB) state_d = RX_PREAM;
          else                     state_d = RX_SKIP;
        end
      end
      RX_PREAM: begin
        if (!dv) begin
          state_d = RX_IDLE;
        end else if (rxd == DELIM_NIB) begin
          state_d     = RX_DATA;
          frame_start = 1'b1;
        end else if (rxd != PREAMBLE_NIB) begin
          state_d = RX_SKIP;
        end
      end
      RX_DATA: begin
        if (dv) begin
          nib_vld = 1'b1;
        end else begin
          frame_end = 1'b1;
          state_d   = RX_IDLE;
        end
      end
      RX_SKIP: begin
        if (!dv) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/mii_rx_byte_asm.sv
module mii_rx_byte_asm
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              nib_vld,
  input  logic              frame_end,
  input  logic [NIB_W-1:0]  rxd,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [BYTE_W-1:0] held_byte,
  output logic              held_first,
  output logic              emit_mid,
  output logic              emit_last,
  output logic              odd_end
);

  logic              half_q, half_d;
  logic [NIB_W-1:0]  low_q, low_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              held_vld_q, held_vld_d;
  logic              first_q, first_d;

  always_comb begin
    byte_done = nib_vld & half_q;
    byte_val  = {rxd, low_q};
    emit_mid  = byte_done & held_vld_q;
    emit_last = frame_end & held_vld_q;
    odd_end   = frame_end & half_q;
    held_byte = held_q;
    held_first = first_q;
  end

  always_comb begin
    half_d     = half_q;
    low_d      = low_q;
    held_d     = held_q;
    held_vld_d = held_vld_q;
    first_d    = first_q;
    if (frame_start || frame_end) begin
      half_d     = 1'b0;
      held_vld_d = 1'b0;
      first_d    = 1'b0;
    end else if (nib_vld) begin
      if (!half_q) begin
        low_d  = rxd;
        half_d = 1'b1;
      end else begin
        half_d     = 1'b0;
        held_d     = byte_val;
        held_vld_d = 1'b1;
        first_d    = ~held_vld_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      low_q      <= '0;
      held_q     <= '0;
      held_vld_q <= 1'b0;
      first_q    <= 1'b0;
    end else begin
      half_q     <= half_d;
      low_q      <= low_d;
      held_q     <= held_d;
      held_vld_q <= held_vld_d;
      first_q    <= first_d;
    end
  end

endmodule

// File: rtl/mii_rx_crc_chk.sv
module mii_rx_crc_chk
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              crc_match
);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = frame_start | byte_done;
    if (frame_start) crc_d = CRC_SEED;
    else             crc_d = crc_step_byte(crc_q, byte_val);
    crc_match = (crc_q == CRC_GOOD_REM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

endmodule

// File: rtl/mii_rx_len_cnt.sv
module mii_rx_len_cnt #(
  parameter int unsigned MIN_FRAME_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic byte_done,
  output logic short_frame
);

  localparam int unsigned CNT_W = $clog2(MIN_FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MIN_FRAME_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = frame_start | (byte_done & (cnt_q != CNT_CAP));
    if (frame_start) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
    short_frame = (cnt_q < CNT_CAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
  import mii_rx_pkg::*;
#(
  parameter int unsigned MIN_FRAME_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mii_dv,
  input  logic [3:0]  mii_rxd,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_crc_ok,
  output logic        out_odd,
  output logic        out_runt
);

  logic              frame_start, nib_vld, frame_end;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val, held_byte;
  logic              held_first, emit_mid, emit_last, odd_end;
  logic              crc_match, short_frame;
  logic              emit_any;

  mii_rx_sfd_fsm i_sfd (
    .clk         (clk),
    .rst_n       (rst_n),
    .dv          (mii_dv),
    .rxd         (mii_rxd),
    .frame_start (frame_start),
    .nib_vld     (nib_vld),
    .frame_end   (frame_end)
  );

  mii_rx_byte_asm i_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .nib_vld     (nib_vld),
    .frame_end   (frame_end),
    .rxd         (mii_rxd),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .held_byte   (held_byte),
    .held_first  (held_first),
    .emit_mid    (emit_mid),
    .emit_last   (emit_last),
    .odd_end     (odd_end)
  );

  mii_rx_crc_chk i_crc (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .crc_match   (crc_match)
  );

  mii_rx_len_cnt #(.MIN_FRAME_BYTES(MIN_FRAME_BYTES)) i_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_done   (byte_done),
    .short_frame (short_frame)
  );

  logic       valid_d, sof_d, eof_d, ok_d, odd_d, runt_d;
  logic [7:0] data_d;

  always_comb begin
    emit_any = emit_mid | emit_last;
    valid_d  = emit_any;
    data_d   = held_byte;
    sof_d    = emit_any & held_first;
    eof_d    = emit_last;
    ok_d     = emit_last & crc_match;
    odd_d    = emit_last & odd_end;
    runt_d   = emit_last & short_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_crc_ok <= 1'b0;
      out_odd    <= 1'b0;
      out_runt   <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_sof    <= sof_d;
      out_eof    <= eof_d;
      out_crc_ok <= ok_d;
      out_odd    <= odd_d;
      out_runt   <= runt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_data <= '0;
    else if (emit_any) out_data <= data_d;
  end

endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic mii_dv,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic out_crc_ok,
  input logic out_odd,
  input logic out_runt
);

  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else if (out_valid && out_eof) open_q <= 1'b0;
    else if (out_valid && out_sof) open_q <= 1'b1;
  end

  p_markers_need_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

  p_sof_not_nested_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !open_q);

  p_body_inside_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> open_q);

  p_crc_flag_on_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_crc_ok |-> out_eof);

  p_odd_flag_on_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_odd |-> out_eof);

  p_runt_flag_on_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_runt |-> out_eof);

  p_eof_after_dv_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (!$past(mii_dv) && $past(mii_dv, 2)));

  p_mid_byte_while_dv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> $past(mii_dv));

endmodule

bind mii_rx_deframer mii_rx_deframer_chk i_chk (.*);

// File: tb/test_mii_rx_deframer.sv
module test_mii_rx_deframer;

  typedef struct packed {
    logic [7:0] d;
    logic       sof;
    logic       eof;
    logic       ok;
    logic       odd;
    logic       runt;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       mii_dv;
  logic [3:0] mii_rxd;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sof, out_eof, out_crc_ok, out_odd, out_runt;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   spurious = 0;
  int   dv_low_edges = 0;
  bit   finished = 0;
  exp_t sb[$];

  mii_rx_deframer i_mii_rx_deframer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mii_dv     (mii_dv),
    .mii_rxd    (mii_rxd),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_crc_ok (out_crc_ok),
    .out_odd    (out_odd),
    .out_runt   (out_runt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) dv_low_edges <= mii_dv ? 0 : dv_low_edges + 1;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      c ^= {24'h0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        spurious++;
        check(1'b0, "R3/R4 unexpected byte", out_data, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_data == e.d,     "R1/R2/R6 data", out_data, e.d);
        check(out_sof == e.sof,    "R5 sof", out_sof, e.sof);
        check(out_eof == e.eof,    "R5 eof", out_eof, e.eof);
        check(out_crc_ok == e.ok,  "R7 crc_ok", out_crc_ok, e.ok);
        check(out_odd == e.odd,    "R8 odd", out_odd, e.odd);
        check(out_runt == e.runt,  "R9 runt", out_runt, e.runt);
        if (e.eof) check(dv_low_edges == 1, "R10 last byte timing", dv_low_edges, 1);
      end
    end
  end

  task automatic nib(input logic [3:0] v);
    @(negedge clk);
    mii_dv  = 1'b1;
    mii_rxd = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mii_dv  = 1'b0;
      mii_rxd = 4'h0;
    end
  endtask

  task automatic send_frame(input int pre_nibs, input int n, input bit add_fcs,
                            input bit corrupt, input bit odd_tail, input logic [7:0] seed,
                            input int gap);
    logic [7:0]  q[$];
    logic [31:0] c, fcs;
    bit          ok;
    for (int i = 0; i < n; i++) q.push_back(seed + 8'(i * 37) ^ 8'(i >> 2));
    if (add_fcs) begin
      fcs = ~ref_crc(q);
      for (int i = 0; i < 4; i++) q.push_back(fcs[8*i +: 8]);
    end
    if (corrupt) q[0] = q[0] ^ 8'h04;
    c  = ref_crc(q);
    ok = (c == 32'hDEBB20E3);
    foreach (q[i]) begin
      exp_t e;
      e.d    = q[i];
      e.sof  = (i == 0);
      e.eof  = (i == q.size() - 1);
      e.ok   = e.eof && ok;
      e.odd  = e.eof && odd_tail;
      e.runt = e.eof && (q.size() < 64);
      sb.push_back(e);
    end
    for (int i = 0; i < pre_nibs; i++) nib(4'h5);
    nib(4'hD);
    foreach (q[i]) begin
      nib(q[i][3:0]);
      nib(q[i][7:4]);
    end
    if (odd_tail) nib(4'hA);
    idle(gap);
  endtask

  task automatic drain(input string req);
    idle(6);
    check(sb.size() == 0, req, sb.size(), 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    mii_dv  = 1'b0;
    mii_rxd = 4'h0;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eof, out_crc_ok, out_odd, out_runt, out_data} == '0,
          "R11 outputs in reset", {out_valid, out_eof, out_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eof, out_crc_ok, out_odd, out_runt, out_data} == '0,
          "R11 outputs after release", {out_valid, out_eof, out_data}, 0);

    // Minimum-size good frame: 60 + 4 bytes
    send_frame(15, 60, 1, 0, 0, 8'h10, 4);
    drain("R6 queue drained after 64-byte frame");
    // Long good frame
    send_frame(15, 100, 1, 0, 0, 8'hA7, 4);
    drain("R6 queue drained after long frame");
    // Runt with good CRC: 59 + 4 = 63 bytes
    send_frame(15, 59, 1, 0, 0, 8'h3C, 4);
    drain("R9 queue drained after runt");
    // Corrupted payload bit
    send_frame(15, 70, 1, 1, 0, 8'h55, 4);
    drain("R7 queue drained after bad frame");
    // Odd trailing nibble
    send_frame(15, 64, 1, 0, 1, 8'h01, 4);
    drain("R8 queue drained after odd frame");
    // Single byte, no check sequence
    send_frame(3, 1, 0, 0, 0, 8'h10, 4);
    drain("R5 single byte frame");

    // Burst that stops inside the preamble
    spurious = 0;
    for (int i = 0; i < 6; i++) nib(4'h5);
    idle(6);
    check(spurious == 0, "R3 aborted preamble produced bytes", spurious, 0);

    // Foreign nibble before a valid-looking delimiter
    nib(4'h5); nib(4'h5); nib(4'h3); nib(4'h5); nib(4'hD);
    for (int i = 0; i < 20; i++) nib(4'(i));
    idle(6);
    check(spurious == 0, "R4 foreign nibble burst produced bytes", spurious, 0);
    // Burst opening on a non-preamble nibble
    nib(4'hD);
    for (int i = 0; i < 10; i++) nib(4'h6);
    idle(6);
    check(spurious == 0, "R4 burst opening on 0xD produced bytes", spurious, 0);

    // Back-to-back frames, one idle cycle, shortest preamble
    send_frame(1, 30, 1, 0, 0, 8'hC3, 1);
    send_frame(1, 61, 1, 0, 0, 8'h9E, 1);
    drain("R2 back-to-back frames drained");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule